// File: doc/BRIEF.md
# Programmable Sample Period Generator

This block produces the internal sample strobe of a sensing subsystem. A single 16-bit period register sets the spacing of the strobes. The low byte carries the whole setting. Bit 7 picks one of two time bases: a short base of roughly 0.61 ms or a long base of roughly 18.9 ms. Bits 6:0 hold a count N. The strobe period equals the chosen base multiplied by N + 1.

The block does not count the system clock directly. It counts a clock-enable tick derived from that clock. The number of ticks in one base unit is a parameter for each base. Real silicon sets these parameters to match the two durations, and a simulation can set them small. After reset the setting is the short base with N = 1, which gives about 819.2 samples per second. A setting of 0x0A with the short base gives about a 6.7 ms period, or about 149 samples per second.

Any setting of 0x0A or above, which includes every long-base setting, raises a low-power mode flag. A write to the register restarts the period count, so the first strobe after a write already uses the new period.

Top module: `smp_period_gen`

## Requirements
- R1: While reset is held and directly after it, cfg_rd reads 0x0001, strobe is 0 and low_power is 0.
- R2: A write (wr_en high at a clock edge) loads wr_data[7:0] into the setting. From the next cycle cfg_rd returns that byte in bits 7:0, and bits 15:8 read as zero whatever was written there.
- R3: The strobe period is BASE x (N + 1) ticks. N is setting bits 6:0. BASE is SHORT_TICKS when setting bit 7 is 0 and LONG_TICKS when bit 7 is 1.
- R4: strobe is high for exactly one clock cycle per period.
- R5: A write clears the period count, and any tick in the write cycle is discarded. The first strobe after the write comes on the clock edge of the P-th tick after that cycle, where P is the new period. No strobe appears in the cycle after a write.
- R6: low_power is 1 exactly when the setting byte, read as an unsigned number, is 0x0A or greater. It follows a write from the next cycle.
- R7: Only cycles with tick high advance the count. With tick held low no strobe appears. The period measured in clock cycles is the period in ticks times the tick spacing.
- R8: After reset the strobe repeats every SHORT_TICKS x 2 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable that advances the period count |
| wr_en | input | 1 | Write strobe for the period register |
| wr_data | input | 16 | Write data; only bits 7:0 are stored |
| cfg_rd | output | 16 | Period register readback, upper byte zero |
| strobe | output | 1 | Single-cycle sample strobe |
| low_power | output | 1 | High when the setting is 0x0A or greater |

## Verification
The bench measures first-strobe latency after writes to settings that straddle the low-power threshold (0x09 and 0x0A), both time bases, N = 0, and the largest N. A design that counted N instead of N + 1, mixed up the bases, or let the tick in the write cycle count would be one base unit or one tick off. It also rewrites the setting in the middle of a period. A design that did not restart the count would strobe early there. It holds tick low and spaces ticks out, which exposes a count that runs on the raw clock. It also writes junk into the upper byte and checks that the readback stays zero, and it confirms that the strobe never stays high for a second cycle.

// File: rtl/smp_pkg.sv
package smp_pkg;

    localparam int CFG_W  = 8;
    localparam int MULT_W = 7;

    // Stored period setting: time base select on top, multiplier below
    typedef struct packed {
        logic              long_base;
        logic [MULT_W-1:0] mult;
    } smp_cfg_t;

endpackage

// File: rtl/smp_cfg_reg.sv
module smp_cfg_reg
    import smp_pkg::*;
#(
    parameter logic [CFG_W-1:0] RST_CFG   = 8'h01,
    parameter logic [CFG_W-1:0] LP_THRESH = 8'h0A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_byte,
    output smp_cfg_t         cfg,
    output logic             low_power
);

    typedef struct packed {
        smp_cfg_t cfg;
        logic     lp;
    } cfg_state_t;

    localparam cfg_state_t RST_STATE = '{
        cfg: smp_cfg_t'(RST_CFG),
        lp:  (RST_CFG >= LP_THRESH)
    };

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg = smp_cfg_t'(wr_byte);
            st_d.lp  = (wr_byte >= LP_THRESH);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign cfg       = st_q.cfg;
    assign low_power = st_q.lp;

endmodule

// File: rtl/smp_base_div.sv
module smp_base_div #(
    parameter int SHORT_TICKS = 3,
    parameter int LONG_TICKS  = 7,
    parameter int SUB_W       = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic long_base,
    output logic unit_done
);

    localparam int MAX_TICKS = (SHORT_TICKS > LONG_TICKS) ? SHORT_TICKS : LONG_TICKS;

    generate
        if (MAX_TICKS <= 1) begin : g_passthru
            // One tick per base unit: no prescaler state needed
            assign unit_done = tick && !clr;
        end else begin : g_count
            localparam logic [SUB_W-1:0] SHORT_LAST = SUB_W'(SHORT_TICKS - 1);
            localparam logic [SUB_W-1:0] LONG_LAST  = SUB_W'(LONG_TICKS - 1);

            typedef struct packed {
                logic [SUB_W-1:0] sub;
            } div_state_t;

            div_state_t       st_d, st_q;
            logic [SUB_W-1:0] last;
            logic             wrap;

            always_comb begin
                last = long_base ? LONG_LAST : SHORT_LAST;
                wrap = tick && !clr && (st_q.sub == last);
                st_d = st_q;
                if (clr)       st_d.sub = '0;
                else if (wrap) st_d.sub = '0;
                else if (tick) st_d.sub = st_q.sub + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign unit_done = wrap;
        end
    endgenerate

endmodule

// File: rtl/smp_unit_cnt.sv
module smp_unit_cnt #(
    parameter int MULT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              unit_done,
    input  logic [MULT_W-1:0] mult,
    output logic              strobe
);

    typedef struct packed {
        logic [MULT_W-1:0] units;
        logic              stb;
    } unit_state_t;

    unit_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (clr) begin
            st_d.units = '0;
        end else if (unit_done) begin
            if (st_q.units == mult) begin
                st_d.units = '0;
                st_d.stb   = 1'b1;
            end else begin
                st_d.units = st_q.units + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = st_q.stb;

endmodule

// File: rtl/smp_period_gen.sv
module smp_period_gen
    import smp_pkg::*;
#(
    parameter int               SHORT_TICKS = 3,
    parameter int               LONG_TICKS  = 7,
    parameter int               DATA_W      = 16,
    parameter logic [CFG_W-1:0] RST_CFG     = 8'h01,
    parameter logic [CFG_W-1:0] LP_THRESH   = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cfg_rd,
    output logic              strobe,
    output logic              low_power
);

    localparam int MAX_TICKS = (SHORT_TICKS > LONG_TICKS) ? SHORT_TICKS : LONG_TICKS;
    localparam int SUB_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;

    smp_cfg_t cfg;
    logic     unit_done;

    smp_cfg_reg #(
        .RST_CFG   (RST_CFG),
        .LP_THRESH (LP_THRESH)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_byte   (wr_data[CFG_W-1:0]),
        .cfg       (cfg),
        .low_power (low_power)
    );

    smp_base_div #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS),
        .SUB_W       (SUB_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (wr_en),
        .tick      (tick),
        .long_base (cfg.long_base),
        .unit_done (unit_done)
    );

    smp_unit_cnt #(
        .MULT_W (MULT_W)
    ) u_units (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (wr_en),
        .unit_done (unit_done),
        .mult      (cfg.mult),
        .strobe    (strobe)
    );

    assign cfg_rd = {{(DATA_W-CFG_W){1'b0}}, cfg};

endmodule

// File: rtl/smp_period_gen_chk.sv
module smp_period_gen_chk #(
    parameter int         SHORT_TICKS = 3,
    parameter int         LONG_TICKS  = 7,
    parameter int         DATA_W      = 16,
    parameter logic [7:0] LP_THRESH   = 8'h0A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] cfg_rd,
    input logic              strobe,
    input logic              low_power
);

    p_rd_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd[DATA_W-1:8] == '0);

    p_wr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_rd[7:0] == $past(wr_data[7:0])));

    p_lp_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        low_power == (cfg_rd[7:0] >= LP_THRESH));

    p_tick_needed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(tick));

    generate
        if (SHORT_TICKS > 1 && LONG_TICKS > 1) begin : g_multi
            // R4: a period of two or more ticks never keeps the strobe up twice
            p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
                strobe |=> !strobe);

            // R5: the count restarts on a write, so no strobe follows at once
            p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> !strobe);
        end
    endgenerate

endmodule

bind smp_period_gen smp_period_gen_chk #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .DATA_W      (DATA_W),
    .LP_THRESH   (LP_THRESH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cfg_rd    (cfg_rd),
    .strobe    (strobe),
    .low_power (low_power)
);

// File: tb/sim_smp_period_gen.sv
`timescale 1ns/1ps
module sim_smp_period_gen;

    localparam int SHORT_T = 3;
    localparam int LONG_T  = 7;
    localparam int LIM     = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] cfg_rd;
    logic        strobe;
    logic        low_power;

    int errors = 0;
    int checks = 0;
    int tdiv = 1;
    int tcnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    smp_period_gen #(.SHORT_TICKS(SHORT_T), .LONG_TICKS(LONG_T)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_rd(cfg_rd), .strobe(strobe), .low_power(low_power)
    );

    // Tick generator: one tick every tdiv cycles, none when tdiv is 0
    always @(negedge clk) begin
        if (tdiv == 0) begin
            tick <= 1'b0; tcnt <= 0;
        end else if (tcnt >= tdiv - 1) begin
            tick <= 1'b1; tcnt <= 0;
        end else begin
            tick <= 1'b0; tcnt <= tcnt + 1;
        end
    end

    typedef struct packed {
        logic [7:0] cfg;
        int         div;
        int         per;
        logic       lp;
    } vec_t;

    // setting, tick spacing, expected period in clocks, expected flag
    localparam vec_t VECS[9] = '{
        '{8'h01, 1,   6, 1'b0},
        '{8'h09, 1,  30, 1'b0},
        '{8'h0A, 1,  33, 1'b1},
        '{8'h00, 1,   3, 1'b0},
        '{8'h80, 1,   7, 1'b1},
        '{8'h83, 1,  28, 1'b1},
        '{8'h7F, 1, 384, 1'b1},
        '{8'h01, 3,  18, 1'b0},
        '{8'h85, 2,  84, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // clocks from the write edge until the first strobe is seen
    task automatic first_strobe(output int k);
        k = 0;
        while (!strobe && k < LIM) begin
            @(negedge clk); k++;
        end
    endtask

    // clocks between two strobes; also checks the single-cycle width
    task automatic interval(input string req, output int k);
        int w;
        w = 0;
        while (!strobe && w < LIM) begin
            @(negedge clk); w++;
        end
        @(negedge clk);
        k = 1;
        chk(!strobe, "R4 strobe width", int'(strobe), 0);
        while (!strobe && k < LIM) begin
            @(negedge clk); k++;
        end
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        // R1: reset state while held
        chk(cfg_rd == 16'h0001, "R1 cfg_rd in reset", cfg_rd, 1);
        chk(strobe == 1'b0, "R1 strobe in reset", strobe, 0);
        chk(low_power == 1'b0, "R1 low_power in reset", low_power, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rd == 16'h0001, "R1 cfg_rd after reset", cfg_rd, 1);
        chk(low_power == 1'b0, "R1 low_power after reset", low_power, 0);
        // R8: default period
        interval("R8", k);
        chk(k == SHORT_T * 2, "R8 default period", k, SHORT_T * 2);

        // Vector table walk
        foreach (VECS[i]) begin
            tdiv = VECS[i].div;
            repeat (4) @(negedge clk);
            do_write({8'hA5, VECS[i].cfg});
            chk(cfg_rd == {8'h00, VECS[i].cfg}, "R2 readback", cfg_rd, {8'h00, VECS[i].cfg});
            chk(low_power == VECS[i].lp, "R6 low_power", low_power, VECS[i].lp);
            if (VECS[i].div == 1) begin
                // write cycle's tick must not count (R5)
                first_strobe(k);
                chk(k == VECS[i].per, "R5 first strobe after write", k, VECS[i].per);
            end
            interval("R3", k);
            chk(k == VECS[i].per, "R3 R7 steady period", k, VECS[i].per);
        end

        // R5: rewrite in the middle of a period restarts the count
        tdiv = 1;
        repeat (4) @(negedge clk);
        do_write(16'h000A);
        repeat (20) @(negedge clk);
        do_write(16'h000A);
        first_strobe(k);
        chk(k == 33, "R5 mid-period restart", k, 33);

        // R7: tick held low, no strobe at all
        tdiv = 0;
        repeat (3) @(negedge clk);
        do_write(16'h0000);
        k = 0;
        repeat (60) begin
            @(negedge clk);
            if (strobe) k++;
        end
        chk(k == 0, "R7 no strobe without tick", k, 0);
        tdiv = 1;
        interval("R7", k);
        chk(k == 3, "R7 resumes on tick", k, 3);

        // R6: threshold boundary from above and below, upper byte ignored (R2)
        do_write(16'hFF09);
        chk(low_power == 1'b0, "R6 setting 0x09", low_power, 0);
        chk(cfg_rd == 16'h0009, "R2 upper byte dropped", cfg_rd, 16'h0009);
        do_write(16'h000A);
        chk(low_power == 1'b1, "R6 setting 0x0A", low_power, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule